// File: doc/BRIEF.md
# USB Line-State Connect Detector

This block watches the two single-ended USB data line levels and turns them into a debounced connection state. The state says whether a device is attached and, if it is, at which speed: low speed or full speed. The raw line levels first pass through a synchronizer. A two-state debounce machine then requires a new line pattern to stay steady for a programmable number of sample clocks before it accepts it. A short disturbance restarts the qualification and leaves the reported state as it was.

Two sticky interrupt flags come from the qualified pattern. The connection-event flag is for the host side. It sets whenever the reported connection class changes. The reset-event flag is for the device side. It sets whenever both lines low (SE0) becomes the qualified pattern. Each flag is cleared by writing a one to its bit of the clear mask.

The debounce machine has two states:
- **DB_STEADY**: the sampled pattern matches the qualified one. When a different pattern is sampled, the machine takes one of two transitions:
  - *start*: it moves to DB_QUALIFY with a count of one.
  - *accept-at-once*: with an effective hold of one, it takes the new pattern immediately.
- **DB_QUALIFY**: a candidate pattern is being counted. Its transitions are:
  - *abandon*: the sample returns to the qualified pattern, so the machine goes back to DB_STEADY.
  - *restart*: a third pattern appears, which becomes the new candidate with a count of one.
  - *accept*: the candidate has been seen for the hold count, so it is taken and the machine returns to DB_STEADY.
  - *count*: otherwise the count increments.

Top module: `usb_connect_detect`

## Requirements
- R1: After reset, conn_state is 0 (disconnected) and both conn_evt_irq and reset_evt_irq are 0.
- R2: conn_state encoding (the line pattern is {line_dp, line_dm}):
  - 2'b01 gives 1 (low-speed connect).
  - 2'b10 gives 2 (full-speed connect).
  - 2'b00 (SE0) and 2'b11 give 0 (disconnected).
  - The value 3 never appears.
- R3: After the lines change to a pattern and then hold it, conn_state takes the new class at exactly SYNC_STAGES + max(hold_cycles,1) rising edges after the change, and not one edge earlier.
- R4: A pattern that is held for fewer sample clocks than the hold count, and then returns to the qualified pattern, changes neither conn_state nor either interrupt flag.
- R5: If a second new pattern arrives while the first is still qualifying, the count restarts. The latency in R3 is then measured from the last change.
- R6: conn_evt_irq sets on the same edge that conn_state changes value, and it stays set until it is cleared.
- R7: A qualified change between the two disconnected patterns (2'b00 and 2'b11) does not set conn_evt_irq.
- R8: reset_evt_irq sets on the edge at which pattern 2'b00 is qualified after any other pattern.
- R9: When clr_wr is 1, each flag whose bit in clr_mask is 1 is cleared (bit 0 clears conn_evt_irq, bit 1 clears reset_evt_irq). Bits at 0 leave their flag unchanged.
- R10: If a flag's set condition and its clear arrive on the same edge, the set wins.
- R11: A hold_cycles value of 0 behaves as a value of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_dp | input | 1 | Raw D+ line level |
| line_dm | input | 1 | Raw D- line level |
| hold_cycles | input | CNT_W | Number of sample clocks a new pattern must be held |
| clr_wr | input | 1 | Strobe that applies clr_mask as a write-one-to-clear |
| clr_mask | input | 2 | Bit 0 clears the connection event, bit 1 clears the reset event |
| conn_state | output | 2 | 0 disconnected, 1 low speed, 2 full speed |
| conn_evt_irq | output | 1 | Sticky connection-change flag |
| reset_evt_irq | output | 1 | Sticky reset (SE0) flag |

## Verification
The assertions assume that the line inputs are already quasi-static relative to clk once they have passed the synchronizer. They also assume that hold_cycles stays constant while a pattern is qualifying. The stimulus therefore changes the lines and hold_cycles only on falling clock edges, and it changes hold_cycles only after the previous pattern has settled.

The sweep covers every ordered pair of the four line patterns at hold values 0 through 4. It also adds a glitch, a restart and a simultaneous set-and-clear case.

// File: rtl/usbcd_pkg.sv
package usbcd_pkg;

    typedef enum logic [1:0] {
        CS_DISCONN = 2'd0,
        CS_LOW     = 2'd1,
        CS_FULL    = 2'd2
    } conn_state_e;

    typedef enum logic [0:0] {
        DB_STEADY  = 1'b0,
        DB_QUALIFY = 1'b1
    } db_state_e;

    localparam logic [1:0] PAT_SE0  = 2'b00;
    localparam logic [1:0] PAT_LOW  = 2'b01;
    localparam logic [1:0] PAT_FULL = 2'b10;

    // Pattern is {dp, dm}
    function automatic conn_state_e classify(input logic [1:0] pat);
        conn_state_e r;
        case (pat)
            PAT_LOW:  r = CS_LOW;
            PAT_FULL: r = CS_FULL;
            default:  r = CS_DISCONN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usbcd_sync.sv
module usbcd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/usbcd_debounce.sv
module usbcd_debounce
    import usbcd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sample_pat,
    input  logic [CNT_W-1:0] hold_cycles,
    output logic [1:0]       qual_pat,
    output logic [1:0]       next_pat,
    output logic             changed
);
    db_state_e        st, st_n;
    logic [1:0]       cand, cand_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]       qual_n;
    logic [CNT_W-1:0] eff_hold;
    logic             hold_one;
    logic [CNT_W:0]   cnt_inc;

    assign eff_hold = (hold_cycles == '0) ? CNT_W'(1) : hold_cycles;
    assign hold_one = (eff_hold == CNT_W'(1));
    assign cnt_inc  = {1'b0, cnt} + 1'b1;

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= DB_STEADY;
            cand     <= PAT_SE0;
            cnt      <= '0;
            qual_pat <= PAT_SE0;
        end else begin
            st       <= st_n;
            cand     <= cand_n;
            cnt      <= cnt_n;
            qual_pat <= qual_n;
        end
    end

    // Transitions and outputs
    always_comb begin
        st_n    = st;
        cand_n  = cand;
        cnt_n   = cnt;
        qual_n  = qual_pat;
        changed = 1'b0;
        unique case (st)
            DB_STEADY: begin
                if (sample_pat != qual_pat) begin
                    if (hold_one) begin
                        qual_n  = sample_pat;       // accept-at-once
                        changed = 1'b1;
                    end else begin
                        st_n   = DB_QUALIFY;        // start
                        cand_n = sample_pat;
                        cnt_n  = CNT_W'(1);
                    end
                end
            end
            DB_QUALIFY: begin
                if (sample_pat == qual_pat) begin
                    st_n  = DB_STEADY;              // abandon
                    cnt_n = '0;
                end else if (sample_pat != cand) begin
                    if (hold_one) begin
                        qual_n  = sample_pat;
                        changed = 1'b1;
                        st_n    = DB_STEADY;
                        cnt_n   = '0;
                    end else begin
                        cand_n = sample_pat;        // restart
                        cnt_n  = CNT_W'(1);
                    end
                end else if (cnt_inc >= {1'b0, eff_hold}) begin
                    qual_n  = cand;                 // accept
                    changed = 1'b1;
                    st_n    = DB_STEADY;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_inc[CNT_W-1:0];     // count
                end
            end
        endcase
    end

    assign next_pat = qual_n;

    // R4: a sample equal to the qualified pattern never moves it
    a_r4_hold_when_match: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pat == qual_pat) |=> $stable(qual_pat));

    // R3: the qualified pattern only ever takes a value that was sampled
    a_r3_qual_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(qual_pat) |-> (qual_pat == $past(sample_pat)));
endmodule

// File: rtl/usbcd_events.sv
module usbcd_events
    import usbcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       changed,
    input  logic [1:0] old_pat,
    input  logic [1:0] new_pat,
    input  logic       clr_wr,
    input  logic [1:0] clr_mask,
    output logic       conn_irq,
    output logic       rst_irq
);
    logic set_conn, set_rst;

    assign set_conn = changed && (classify(new_pat) != classify(old_pat));
    assign set_rst  = changed && (new_pat == PAT_SE0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_irq <= 1'b0;
            rst_irq  <= 1'b0;
        end else begin
            if (set_conn)                     conn_irq <= 1'b1;
            else if (clr_wr && clr_mask[0])   conn_irq <= 1'b0;
            if (set_rst)                      rst_irq  <= 1'b1;
            else if (clr_wr && clr_mask[1])   rst_irq  <= 1'b0;
        end
    end

    // R9: a bit left at zero keeps its flag
    a_r9_mask_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !clr_mask[1] && rst_irq) |=> rst_irq);
endmodule

// File: rtl/usb_connect_detect.sv
module usb_connect_detect
    import usbcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_dp,
    input  logic             line_dm,
    input  logic [CNT_W-1:0] hold_cycles,
    input  logic             clr_wr,
    input  logic [1:0]       clr_mask,
    output logic [1:0]       conn_state,
    output logic             conn_evt_irq,
    output logic             reset_evt_irq
);
    logic [1:0] sync_pat;
    logic [1:0] qual_pat;
    logic [1:0] next_pat;
    logic       changed;

    usbcd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({line_dp, line_dm}),
        .d_out (sync_pat)
    );

    usbcd_debounce #(.CNT_W(CNT_W)) u_db (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_pat  (sync_pat),
        .hold_cycles (hold_cycles),
        .qual_pat    (qual_pat),
        .next_pat    (next_pat),
        .changed     (changed)
    );

    usbcd_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .changed  (changed),
        .old_pat  (qual_pat),
        .new_pat  (next_pat),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .conn_irq (conn_evt_irq),
        .rst_irq  (reset_evt_irq)
    );

    assign conn_state = classify(qual_pat);

    // R2: encoding 3 is never produced
    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        conn_state != 2'b11);

    // R6: a rising connection event accompanies a state change
    a_r6_evt_with_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_evt_irq) |-> (conn_state != $past(conn_state)));

    // R8: a rising reset event only with a disconnected state
    a_r8_reset_when_disc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_evt_irq) |-> (conn_state == CS_DISCONN));

    // R9/R10: clear works unless a new change lands on that edge
    a_r9_clear_conn: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[0]) |=> (!conn_evt_irq || !$stable(conn_state)));
endmodule

// File: tb/tb_usb_connect_detect.sv
module tb_usb_connect_detect;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int CW         = 8;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_dp = 1'b0, line_dm = 1'b0;
    logic [CW-1:0] hold_cycles = '0;
    logic          clr_wr = 1'b0;
    logic [1:0]    clr_mask = 2'b00;
    logic [1:0]    conn_state;
    logic          conn_evt_irq, reset_evt_irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    usb_connect_detect #(.SYNC_STAGES(SYNC), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
        .hold_cycles(hold_cycles), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .conn_state(conn_state), .conn_evt_irq(conn_evt_irq),
        .reset_evt_irq(reset_evt_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int cls(input logic [1:0] p);
        return (p == 2'b01) ? 1 : (p == 2'b10) ? 2 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] p);
        {line_dp, line_dm} = p;
    endtask

    task automatic clear(input logic [1:0] m);
        clr_wr = 1'b1; clr_mask = m;
        edges(1);
        clr_wr = 1'b0; clr_mask = 2'b00;
    endtask

    task automatic settle(input logic [1:0] p);
        drive(p);
        edges(SYNC + int'(hold_cycles) + 6);
        clear(2'b11);
    endtask

    // one transition from a settled pattern to another
    task automatic transition(input logic [1:0] from, input logic [1:0] to, input int hold);
        int lat;
        string tag;
        hold_cycles = CW'(hold);
        tag = (hold == 0) ? "R11" : "R3";
        settle(from);
        chk("R9 cleared conn", int'(conn_evt_irq), 0);
        drive(to);
        lat = SYNC + ((hold < 1) ? 1 : hold);
        edges(lat - 1);
        chk({tag, " before"}, int'(conn_state), cls(from));
        edges(1);
        chk({tag, " R2 after"}, int'(conn_state), cls(to));
        chk((cls(from) == 0 && cls(to) == 0) ? "R7" : "R6", int'(conn_evt_irq),
            int'(cls(from) != cls(to)));
        chk("R8", int'(reset_evt_irq), int'(to == 2'b00 && from != 2'b00));
    endtask

    initial begin
        drive(2'b00);
        edges(3);
        rst_n = 1'b1;
        edges(2);
        chk("R1 state", int'(conn_state), 0);
        chk("R1 conn irq", int'(conn_evt_irq), 0);
        chk("R1 reset irq", int'(reset_evt_irq), 0);

        for (int h = 0; h <= 4; h++)
            for (int f = 0; f < 4; f++)
                for (int t = 0; t < 4; t++)
                    if (f != t) transition(2'(f), 2'(t), h);

        // R4: glitch shorter than hold
        hold_cycles = 4;
        settle(2'b01);
        drive(2'b10);
        edges(3);
        drive(2'b01);
        edges(SYNC + 10);
        chk("R4 state", int'(conn_state), 1);
        chk("R4 conn irq", int'(conn_evt_irq), 0);
        chk("R4 reset irq", int'(reset_evt_irq), 0);

        // R5: restart on a third pattern
        hold_cycles = 3;
        settle(2'b01);
        drive(2'b10);
        edges(2);
        drive(2'b00);
        edges(SYNC + 3 - 1);
        chk("R5 before", int'(conn_state), 1);
        edges(1);
        chk("R5 after", int'(conn_state), 0);

        // R9: independent clear bits
        chk("R9 both set conn", int'(conn_evt_irq), 1);
        chk("R9 both set reset", int'(reset_evt_irq), 1);
        clear(2'b00);
        chk("R9 zero mask conn", int'(conn_evt_irq), 1);
        chk("R9 zero mask reset", int'(reset_evt_irq), 1);
        clear(2'b01);
        chk("R9 bit0 conn", int'(conn_evt_irq), 0);
        chk("R9 bit0 keeps reset", int'(reset_evt_irq), 1);
        clear(2'b10);
        chk("R9 bit1 reset", int'(reset_evt_irq), 0);

        // R10: set beats clear on the same edge
        hold_cycles = 2;
        settle(2'b01);
        drive(2'b00);
        edges(SYNC + 2 - 1);
        clr_wr = 1'b1; clr_mask = 2'b11;
        edges(1);
        clr_wr = 1'b0; clr_mask = 2'b00;
        chk("R10 conn", int'(conn_evt_irq), 1);
        chk("R10 reset", int'(reset_evt_irq), 1);
        chk("R10 state", int'(conn_state), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule